// File: doc/BRIEF.md
# Time Capture and Interrupt Aggregator

This block watches two general-purpose input pins. Each pin goes through a two-flop synchronizer and a pulse-width qualifier. The qualifier recognises an edge only when the pin moves from its idle level to its active level and then stays active for a set number of synchronized cycles. A recognised edge does three things. It latches the free-running 64-bit precision time into that pin's capture register. It sets that pin's capture status bit. It clears the clock-target timer status bit, so a pin can acknowledge a compare event.

The block also holds status bits for the transmit and receive timestamp indications of every switch port and for the clock compare event. Those sources arrive as one-cycle pulses from the timestamp and comparator logic nearby. Every status bit has its own enable bit. The enabled bits are ORed into one summary interrupt. Software clears status bits by writing ones. A capture register keeps its first timestamp until its status bit has been cleared.

Top module: `tcap_irq_agg`

## Requirements
- R1: While `rst_n` is low, and right after reset, `irq_sts`, `cap_time` and `irq_out` are all zero.
- R2: A pin event is recognised only after the synchronized pin goes from idle to active and then reads active on `QUAL_CYC` consecutive cycles (default 4). A shorter active pulse is ignored. One active period gives at most one event, however long it lasts. A pin that is already active when reset ends gives no event.
- R3: `gpio_pol[i]` = 1 makes high the active level of pin i (rising edge). `gpio_pol[i]` = 0 makes low the active level (falling edge).
- R4: Suppose a pin changes to active away from a clock edge and stays active. The status bit and the capture then take effect at the (`QUAL_CYC`+2)-th rising edge after the change, and not before.
- R5: A pin event sets status bit `2*NUM_PORTS+i` (bits 6 and 7 by default). It loads the `time_now` value present at that edge into `cap_time` half i: bits [63:0] for pin 0 and bits [127:64] for pin 1.
- R6: A pin event leaves the capture register unchanged while that pin's status bit is set. The exception is a write-1 clear of that bit in the same cycle, which lets the new value in.
- R7: A pin event clears the timer status bit `2*NUM_PORTS+2` (bit 8 by default).
- R8: Status bits are set by pulses. `tx_ts_pulse[p]` sets bit p. `rx_ts_pulse[p]` sets bit `NUM_PORTS+p`. `cmp_evt` sets the timer bit.
- R9: A cycle with `clr_we` high clears every status bit whose `clr_mask` bit is 1, and the bits stay set until then. A set event in the same cycle as any clear, whether written or caused by a pin, wins.
- R10: `irq_out` is high exactly when some status bit and its `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| time_now | input | TIME_W | Current precision time |
| gpio_in | input | 2 | Asynchronous event pins |
| gpio_pol | input | 2 | Active level per pin (1 = high) |
| tx_ts_pulse | input | NUM_PORTS | Transmit timestamp indication per port |
| rx_ts_pulse | input | NUM_PORTS | Receive timestamp indication per port |
| cmp_evt | input | 1 | Clock compare event pulse |
| irq_en | input | NSRC | Enable per status bit |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | NSRC | Bits to clear when `clr_we` is high |
| irq_sts | output | NSRC | Status bits |
| cap_time | output | 2*TIME_W | Capture registers, pin 0 in the low half |
| irq_out | output | 1 | Summary interrupt |

## Verification
Two functions can act on the timer status bit in one cycle. A qualified pin edge clears it, and a clock compare pulse sets it. The bench places the pin change on a known falling edge. It counts `QUAL_CYC`+1 rising edges and raises `cmp_evt` exactly in the cycle where the qualified event is pending. The timer bit must then read 1 and the pin's status bit must turn on at that same edge, not one earlier. The same exact timing is used to put a write-1 clear of a pin's status bit in the cycle of a new pin event. In that case the capture must take the new time.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int unsigned TCAP_NGPIO = 2;

  // status layout: tx per port, rx per port, pin captures, timer
  function automatic int unsigned tcap_nsrc(input int unsigned nports);
    return 2 * nports + TCAP_NGPIO + 1;
  endfunction
endpackage

// File: rtl/tcap_edge_qual.sv
module tcap_edge_qual #(
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic evt
);
  localparam int unsigned CNT_W = $clog2(QUAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYC);
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(QUAL_CYC - 1);

  logic             sync1_q, sync2_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
    end
  end

  assign act = (sync2_q == pol);

  // counter starts saturated: an idle level must be seen before an edge
  always_comb begin
    cnt_d = cnt_q;
    if (!act)                cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MAX;
    else        cnt_q <= cnt_d;
  end

  assign evt = act && (cnt_q == CNT_HIT);

  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  assert_held_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(act));
endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] time_now,
  output logic [TIME_W-1:0] cap
);
  logic [TIME_W-1:0] cap_q, cap_d;

  always_comb begin
    cap_d = cap_q;
    if (load) cap_d = time_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap = cap_q;
endmodule

// File: rtl/tcap_sts_bank.sv
module tcap_sts_bank #(
  parameter int unsigned NSRC = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_v,
  input  logic [NSRC-1:0] clr_v,
  output logic [NSRC-1:0] sts
);
  logic [NSRC-1:0] sts_q, sts_d;

  always_comb sts_d = set_v | (sts_q & ~clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((sts_q & $past(set_v)) == $past(set_v)));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts_q) |=> ((($past(sts_q) & ~$past(clr_v)) & ~sts_q) == '0));
endmodule

// File: rtl/tcap_irq_agg.sv
module tcap_irq_agg
  import tcap_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned TIME_W    = 64,
  parameter int unsigned QUAL_CYC  = 4,
  localparam int unsigned NSRC     = tcap_nsrc(NUM_PORTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TIME_W-1:0]          time_now,
  input  logic [TCAP_NGPIO-1:0]      gpio_in,
  input  logic [TCAP_NGPIO-1:0]      gpio_pol,
  input  logic [NUM_PORTS-1:0]       tx_ts_pulse,
  input  logic [NUM_PORTS-1:0]       rx_ts_pulse,
  input  logic                       cmp_evt,
  input  logic [NSRC-1:0]            irq_en,
  input  logic                       clr_we,
  input  logic [NSRC-1:0]            clr_mask,
  output logic [NSRC-1:0]            irq_sts,
  output logic [TCAP_NGPIO*TIME_W-1:0] cap_time,
  output logic                       irq_out
);
  localparam int unsigned G_BASE  = 2 * NUM_PORTS;
  localparam int unsigned TMR_BIT = G_BASE + TCAP_NGPIO;

  logic [TCAP_NGPIO-1:0] gevt;
  logic [TCAP_NGPIO-1:0] load;
  logic [NSRC-1:0]       w1c, set_v, clr_v, sts;

  assign w1c   = clr_we ? clr_mask : '0;
  assign set_v = {cmp_evt, gevt, rx_ts_pulse, tx_ts_pulse};
  assign clr_v = w1c | ({{(NSRC-1){1'b0}}, |gevt} << TMR_BIT);

  for (genvar g = 0; g < TCAP_NGPIO; g++) begin : g_pin
    tcap_edge_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (gpio_in[g]),
      .pol   (gpio_pol[g]),
      .evt   (gevt[g])
    );

    // keep the first timestamp until software has taken it
    assign load[g] = gevt[g] & (~sts[G_BASE+g] | w1c[G_BASE+g]);

    tcap_capture #(.TIME_W(TIME_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[g]),
      .time_now (time_now),
      .cap      (cap_time[g*TIME_W +: TIME_W])
    );

    assert_cap_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[G_BASE+g] && !w1c[G_BASE+g]) |=> $stable(cap_time[g*TIME_W +: TIME_W]));
    assert_pin_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gevt[g] |=> sts[G_BASE+g]);
  end

  tcap_sts_bank #(.NSRC(NSRC)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .sts   (sts)
  );

  assign irq_sts = sts;
  assign irq_out = |(sts & irq_en);

  assert_pin_clears_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gevt) && !cmp_evt) |=> !sts[TMR_BIT]);
endmodule

// File: tb/sim_tcap_irq_agg.sv
module sim_tcap_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 3;
  localparam int TW   = 64;
  localparam int Q    = 4;
  localparam int NS   = 2 * NP + 3;
  localparam int GB   = 2 * NP;
  localparam int TMR  = GB + 2;

  // vector: [7] pin, [6] polarity, [5] event expected, [4:0] active width in cycles
  localparam logic [7:0] VEC [0:7] = '{8'h43, 8'h64, 8'hE4, 8'h83,
                                       8'hA6, 8'h24, 8'h41, 8'hEA};

  logic            clk, rst_n;
  logic [TW-1:0]   time_now;
  logic [1:0]      gpio_in, gpio_pol;
  logic [NP-1:0]   tx_ts_pulse, rx_ts_pulse;
  logic            cmp_evt, clr_we, irq_out;
  logic [NS-1:0]   irq_en, clr_mask, irq_sts;
  logic [2*TW-1:0] cap_time;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tcap_irq_agg #(.NUM_PORTS(NP), .TIME_W(TW), .QUAL_CYC(Q)) u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .gpio_in(gpio_in),
    .gpio_pol(gpio_pol), .tx_ts_pulse(tx_ts_pulse), .rx_ts_pulse(rx_ts_pulse),
    .cmp_evt(cmp_evt), .irq_en(irq_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .irq_sts(irq_sts), .cap_time(cap_time), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr_we = 1'b1; clr_mask = '1;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic pulse(input int g, input logic p, input int w,
                       input logic [TW-1:0] tv, input bit do_clr);
    @(negedge clk); gpio_pol[g] = p; gpio_in[g] = ~p;
    repeat (8) @(negedge clk);
    if (do_clr) clear_all();
    time_now = tv;
    @(negedge clk); gpio_in[g] = p;
    repeat (w) @(negedge clk);
    gpio_in[g] = ~p;
    repeat (8) @(negedge clk);
  endtask

  // drive pin g active and act in the exact cycle the qualified event is pending
  task automatic timed_edge(input int g, input logic [TW-1:0] tv,
                            input logic cmp, input logic [NS-1:0] clr,
                            input string req);
    time_now = tv;
    @(negedge clk); gpio_in[g] = gpio_pol[g];
    repeat (Q + 1) @(posedge clk);
    @(negedge clk);
    chk({req, " not before latency"}, 128'(irq_sts[GB+g]), 128'(clr[GB+g] ? 1'b1 : irq_sts[GB+g]));
    cmp_evt = cmp; clr_we = |clr; clr_mask = clr;
    @(negedge clk);
    cmp_evt = 1'b0; clr_we = 1'b0; clr_mask = '0;
    gpio_in[g] = ~gpio_pol[g];
  endtask

  initial begin
    rst_n = 1'b0; time_now = '0; gpio_in = 2'b00; gpio_pol = 2'b11;
    tx_ts_pulse = '0; rx_ts_pulse = '0; cmp_evt = 1'b0;
    irq_en = '1; clr_we = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 sts in reset", 128'(irq_sts), 128'(0));
    chk("R1 irq in reset", 128'(irq_out), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sts after reset", 128'(irq_sts), 128'(0));
    chk("R1 cap after reset", cap_time, 128'(0));

    // table of pin pulses: R2, R3, R5
    for (int k = 0; k < 8; k++) begin
      automatic int g = int'(VEC[k][7]);
      automatic logic [TW-1:0] tv = 64'h1000_0000_0000_0000 + 64'(k * 17 + 3);
      automatic logic [TW-1:0] capg;
      pulse(g, VEC[k][6], int'(VEC[k][4:0]), tv, 1'b1);
      capg = cap_time[g*TW +: TW];
      chk($sformatf("R2 R3 vec %0d status", k), 128'(irq_sts[GB+g]), 128'(VEC[k][5]));
      if (VEC[k][5]) chk($sformatf("R5 vec %0d capture", k), 128'(capg), 128'(tv));
    end
    @(negedge clk); gpio_pol = 2'b11; gpio_in = 2'b00;
    repeat (8) @(negedge clk);
    clear_all();

    // R8 / R10: port pulses and masking
    @(negedge clk); tx_ts_pulse = 3'b101; rx_ts_pulse = 3'b010;
    @(negedge clk); tx_ts_pulse = '0; rx_ts_pulse = '0;
    chk("R8 tx rx bits", 128'(irq_sts), 128'(9'h015));
    irq_en = '0; #1;
    chk("R10 all masked", 128'(irq_out), 128'(0));
    irq_en = 9'h010; #1;
    chk("R10 enabled rx1", 128'(irq_out), 128'(1));
    irq_en = 9'h002; #1;
    chk("R10 enabled idle bit", 128'(irq_out), 128'(0));
    irq_en = '1;
    @(negedge clk); clr_we = 1'b1; clr_mask = 9'h005;
    @(negedge clk); clr_we = 1'b0; clr_mask = '0;
    chk("R9 w1c partial", 128'(irq_sts), 128'(9'h010));

    // R9: set wins over write clear
    @(negedge clk); tx_ts_pulse = 3'b001; clr_we = 1'b1; clr_mask = 9'h001;
    @(negedge clk); tx_ts_pulse = '0; clr_we = 1'b0; clr_mask = '0;
    chk("R9 set beats w1c", 128'(irq_sts[0]), 128'(1));
    clear_all();

    // R7 / R8: timer set by compare, cleared by a pin
    @(negedge clk); cmp_evt = 1'b1;
    @(negedge clk); cmp_evt = 1'b0;
    chk("R8 timer set", 128'(irq_sts[TMR]), 128'(1));
    pulse(1, 1'b1, 6, 64'h55, 1'b0);
    chk("R7 pin clears timer", 128'(irq_sts[TMR]), 128'(0));
    chk("R5 pin1 status", 128'(irq_sts[GB+1]), 128'(1));
    clear_all();

    // R4 / R9: compare pulse coincides with the pin event
    timed_edge(0, 64'hAAAA, 1'b1, '0, "R4");
    chk("R4 status at latency", 128'(irq_sts[GB]), 128'(1));
    chk("R9 compare beats pin clear", 128'(irq_sts[TMR]), 128'(1));
    chk("R5 capture at latency", 128'(cap_time[TW-1:0]), 128'(64'hAAAA));
    repeat (8) @(negedge clk);

    // R6: first timestamp kept while status set
    pulse(0, 1'b1, 5, 64'hBBBB, 1'b0);
    chk("R6 capture preserved", 128'(cap_time[TW-1:0]), 128'(64'hAAAA));
    chk("R6 status still set", 128'(irq_sts[GB]), 128'(1));

    // R6: clear in the event cycle lets the new time in
    timed_edge(0, 64'hCCCC, 1'b0, 9'(1 << GB), "R6");
    chk("R6 capture after same-cycle clear", 128'(cap_time[TW-1:0]), 128'(64'hCCCC));
    chk("R9 pin set beats w1c", 128'(irq_sts[GB]), 128'(1));
    repeat (8) @(negedge clk);

    // R2: long active period yields one event only
    clear_all();
    @(negedge clk); gpio_in[1] = 1'b1;
    repeat (Q + 4) @(negedge clk);
    chk("R2 long pulse event", 128'(irq_sts[GB+1]), 128'(1));
    clear_all();
    repeat (12) @(negedge clk);
    chk("R2 no second event", 128'(irq_sts[GB+1]), 128'(0));
    @(negedge clk); gpio_in[1] = 1'b0;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule